// File: doc/BRIEF.md
# Processor-Side Split Translation Lookup

This block is the processor half of a translation buffer that is split across a narrow address link. It holds only virtual page numbers, in a fully associative array. It does not translate an address. It tells the far side of the link which of its entries matches, and the far side keeps the physical page number in the slot with the same number. On a hit, the link carries the slot number and the unchanged page offset in one beat. The slot then becomes the most recently used.

On a miss, the block raises a separate miss line for three beats. In those beats the offset lines carry three fields in turn: the upper page-table field, the lower page-table field, and finally the page offset. Throughout the three beats the index lines, which a miss leaves idle, carry the slot that the new entry will replace. The block then stalls new lookups until the returned physical page number is signalled on the fill port. It writes the virtual page number into the chosen slot at that moment.

With the default parameters, the link carries a 12-bit offset and a 6-bit slot number against a 32-bit virtual address.

Top module: `ptlb_proc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `link_valid` is 0 and every slot is empty.
- R2: A request accepted in cycle N whose page number (address bits 31:12) matches a filled slot gives, in cycle N+1, `link_valid`=1, `link_miss`=0 and `link_offset` equal to address bits 11:0.
- R3: A request accepted in cycle N that matches no slot drives `link_valid`=1 and `link_miss`=1 in cycles N+1, N+2 and N+3. `link_offset` is bits 31:22 zero-extended in N+1, bits 21:12 zero-extended in N+2, and bits 11:0 in N+3.
- R4: In all three miss beats, `link_index` carries the same slot number: the slot chosen for replacement.
- R5: From cycle N+1 after a miss is accepted, `req_ready` is 0 until the cycle after `fill_valid` is sampled high in the waiting phase. A request presented while `req_ready` is 0 is ignored.
- R6: `fill_valid` is ignored outside the waiting phase that follows the third miss beat. It neither ends the stall nor installs an entry.
- R7: While any slot is empty, the replacement slot is the lowest-numbered empty slot.
- R8: Once every slot is filled, the replacement slot is the one whose last hit or install is the oldest.
- R9: After a fill, a request with the same page number hits, and `link_index` shows the slot that was filled.
- R10: In any cycle that follows neither an accepted request nor a miss beat, `link_valid` and `link_miss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address to look up |
| req_ready | output | 1 | Block can accept a lookup this cycle |
| fill_valid | input | 1 | Physical page number for the pending miss has returned |
| link_valid | output | 1 | Link beat present |
| link_miss | output | 1 | Beat belongs to a miss transfer |
| link_index | output | 6 | Matching slot on a hit, replacement slot on a miss |
| link_offset | output | 12 | Page offset, or a page-table field during a miss |

## Verification
The properties assume that `fill_valid` is the only way to leave the waiting phase. They also assume that requests are presented only through the `req_valid`/`req_ready` handshake, so no lookup overlaps a miss transfer. The stimulus breaks neither assumption. It still drives `req_valid` while the block stalls and pulses `fill_valid` at random in idle and miss-beat cycles, because those inputs must be ignored. The page numbers come from a reused pool of 80 values mixed with fresh random ones. This fills every slot, and the later replacements then follow least-recent order.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int DEF_VA_W      = 32;
    localparam int DEF_PAGE_BITS = 12;
    localparam int DEF_ENTRIES   = 64;

    // Sequencer phase; the miss phases name the beat on the link
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TOP,
        PH_LOW,
        PH_OFFS,
        PH_WAIT
    } seq_phase_e;

    function automatic int half_width(input int w);
        return w / 2;
    endfunction

endpackage

// File: rtl/ptlb_cam.sv
module ptlb_cam #(
    parameter int ENTRIES = ptlb_pkg::DEF_ENTRIES,
    parameter int VPN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VPN_W-1:0]   look_vpn,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [ENTRIES-1:0] filled
);

    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            tag_q[wr_idx] <= wr_vpn;
        end
    end

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = vld_q[g] && (tag_q[g] == look_vpn);
        end
    endgenerate

    // Index encoder: at most one slot matches, lowest wins otherwise
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit    = |match;
    assign filled = vld_q;

endmodule

// File: rtl/ptlb_lru.sv
module ptlb_lru #(
    parameter int ENTRIES = ptlb_pkg::DEF_ENTRIES,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] filled,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    // Per-slot age: 0 is the most recent; ages form a permutation
    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] touched_age;

    assign touched_age = age_q[touch_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < touched_age)
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!filled[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        old_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (age_q[i] == OLDEST) old_idx = IDX_W'(i);
        end
    end

    assign victim_idx = free_found ? free_idx : old_idx;

endmodule

// File: rtl/ptlb_seq.sv
module ptlb_seq
    import ptlb_pkg::*;
#(
    parameter int VA_W      = DEF_VA_W,
    parameter int PAGE_BITS = DEF_PAGE_BITS,
    parameter int IDX_W     = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [VA_W-1:0]           req_vaddr,
    output logic                      req_ready,
    input  logic                      fill_valid,
    input  logic                      hit,
    input  logic [IDX_W-1:0]          hit_idx,
    input  logic [IDX_W-1:0]          victim_idx,
    output logic                      touch_en,
    output logic [IDX_W-1:0]          touch_idx,
    output logic                      wr_en,
    output logic [IDX_W-1:0]          wr_idx,
    output logic [VA_W-PAGE_BITS-1:0] wr_vpn,
    output logic                      link_valid,
    output logic                      link_miss,
    output logic [IDX_W-1:0]          link_index,
    output logic [PAGE_BITS-1:0]      link_offset
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int LOW_W = half_width(VPN_W);
    localparam int TOP_W = VPN_W - LOW_W;

    seq_phase_e             phase_q;
    logic [VA_W-1:0]        va_q;
    logic [IDX_W-1:0]       vic_q;
    logic                   accept;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign wr_en     = (phase_q == PH_WAIT) && fill_valid;
    assign wr_idx    = vic_q;
    assign wr_vpn    = va_q[VA_W-1:PAGE_BITS];
    assign touch_en  = (accept && hit) || wr_en;
    assign touch_idx = wr_en ? vic_q : hit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            va_q        <= '0;
            vic_q       <= '0;
            link_valid  <= 1'b0;
            link_miss   <= 1'b0;
            link_index  <= '0;
            link_offset <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept && hit) begin
                        link_valid  <= 1'b1;
                        link_miss   <= 1'b0;
                        link_index  <= hit_idx;
                        link_offset <= req_vaddr[PAGE_BITS-1:0];
                    end else if (accept) begin
                        phase_q     <= PH_TOP;
                        va_q        <= req_vaddr;
                        vic_q       <= victim_idx;
                        link_valid  <= 1'b1;
                        link_miss   <= 1'b1;
                        link_index  <= victim_idx;
                        link_offset <= PAGE_BITS'(req_vaddr[VA_W-1 -: TOP_W]);
                    end else begin
                        link_valid  <= 1'b0;
                        link_miss   <= 1'b0;
                    end
                end
                PH_TOP: begin
                    phase_q     <= PH_LOW;
                    link_offset <= PAGE_BITS'(va_q[PAGE_BITS +: LOW_W]);
                end
                PH_LOW: begin
                    phase_q     <= PH_OFFS;
                    link_offset <= va_q[PAGE_BITS-1:0];
                end
                PH_OFFS: begin
                    phase_q    <= PH_WAIT;
                    link_valid <= 1'b0;
                    link_miss  <= 1'b0;
                end
                PH_WAIT: begin
                    if (fill_valid) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ptlb_proc.sv
module ptlb_proc #(
    parameter int VA_W      = ptlb_pkg::DEF_VA_W,
    parameter int PAGE_BITS = ptlb_pkg::DEF_PAGE_BITS,
    parameter int ENTRIES   = ptlb_pkg::DEF_ENTRIES
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [VA_W-1:0]              req_vaddr,
    output logic                         req_ready,
    input  logic                         fill_valid,
    output logic                         link_valid,
    output logic                         link_miss,
    output logic [$clog2(ENTRIES)-1:0]   link_index,
    output logic [PAGE_BITS-1:0]         link_offset
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int IDX_W = $clog2(ENTRIES);

    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [ENTRIES-1:0] filled;
    logic [IDX_W-1:0]   victim_idx;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic [VPN_W-1:0]   wr_vpn;

    ptlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_cam (
        .clk     (clk),
        .rst     (rst),
        .look_vpn(req_vaddr[VA_W-1:PAGE_BITS]),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_vpn  (wr_vpn),
        .hit     (hit),
        .hit_idx (hit_idx),
        .filled  (filled)
    );

    ptlb_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .filled    (filled),
        .victim_idx(victim_idx)
    );

    ptlb_seq #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .req_ready  (req_ready),
        .fill_valid (fill_valid),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .victim_idx (victim_idx),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_vpn     (wr_vpn),
        .link_valid (link_valid),
        .link_miss  (link_miss),
        .link_index (link_index),
        .link_offset(link_offset)
    );

endmodule

// File: rtl/ptlb_checker.sv
module ptlb_checker #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [VA_W-1:0]      req_vaddr,
    input logic                 req_ready,
    input logic                 fill_valid,
    input logic                 link_valid,
    input logic                 link_miss,
    input logic [IDX_W-1:0]     link_index,
    input logic [PAGE_BITS-1:0] link_offset
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (req_ready && !link_valid && !link_miss));

    assert_hit_offset_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (link_valid &&
            (link_miss || link_offset == $past(req_vaddr[PAGE_BITS-1:0]))));

    assert_miss_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
        link_miss |-> link_valid);

    assert_miss_second_beat_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(link_miss) |=> link_miss);

    assert_miss_three_beats_R3: assert property (@(posedge clk) disable iff (rst)
        (link_miss && $past(link_miss, 2)) |=> !link_miss);

    assert_victim_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (link_miss && $past(link_miss)) |-> $stable(link_index));

    assert_stall_in_beats_R5: assert property (@(posedge clk) disable iff (rst)
        link_miss |-> !req_ready);

    assert_stall_after_beats_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(link_miss) |-> !req_ready);

    assert_fill_releases_R6: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !link_valid && fill_valid) |=> req_ready);

    assert_quiet_link_R10: assert property (@(posedge clk) disable iff (rst)
        (!(req_valid && req_ready) && !link_miss) |=> !link_valid);

endmodule

bind ptlb_proc ptlb_checker #(
    .VA_W     (VA_W),
    .PAGE_BITS(PAGE_BITS),
    .IDX_W    ($clog2(ENTRIES))
) u_ptlb_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_ready  (req_ready),
    .fill_valid (fill_valid),
    .link_valid (link_valid),
    .link_miss  (link_miss),
    .link_index (link_index),
    .link_offset(link_offset)
);

// File: tb/test_ptlb_proc.sv
`timescale 1ns/1ps
module test_ptlb_proc;

    localparam int ENTRIES = 64;
    localparam int POOL    = 80;
    localparam int CYCLES  = 6000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        fill_valid = 1'b0;
    logic        req_ready;
    logic        link_valid;
    logic        link_miss;
    logic [5:0]  link_index;
    logic [11:0] link_offset;

    always #4 clk = ~clk;

    ptlb_proc i_ptlb_proc (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .req_ready  (req_ready),
        .fill_valid (fill_valid),
        .link_valid (link_valid),
        .link_miss  (link_miss),
        .link_index (link_index),
        .link_offset(link_offset)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference: slot contents, recency list, phase number
    logic [19:0] m_vpn [ENTRIES];
    bit          m_vld [ENTRIES];
    int          m_recent [$];
    int          m_phase = 0;
    bit          e_valid = 0, e_miss = 0, e_free = 0, spur = 0;
    int          e_idx = 0, e_off = 0, m_vic = 0;
    logic [31:0] m_va = '0;
    logic [19:0] pool [POOL];

    function automatic void touch(int s);
        for (int k = 0; k < m_recent.size(); k++) begin
            if (m_recent[k] == s) begin
                m_recent.delete(k);
                break;
            end
        end
        m_recent.push_front(s);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; e_valid = 0; e_miss = 0; spur = 0;
            for (int s = 0; s < ENTRIES; s++) m_vld[s] = 0;
            m_recent.delete();
        end else begin
            spur = fill_valid && (m_phase != 4);
            case (m_phase)
                0: begin
                    if (req_valid) begin
                        int h;
                        h = -1;
                        for (int s = 0; s < ENTRIES; s++)
                            if (m_vld[s] && m_vpn[s] == req_vaddr[31:12]) h = s;
                        e_valid = 1;
                        if (h >= 0) begin
                            e_miss = 0; e_idx = h; e_off = int'(req_vaddr[11:0]);
                            touch(h);
                        end else begin
                            m_vic = -1;
                            for (int s = ENTRIES - 1; s >= 0; s--)
                                if (!m_vld[s]) m_vic = s;
                            e_free = (m_vic >= 0);
                            if (!e_free) m_vic = m_recent[$];
                            m_va = req_vaddr;
                            e_miss = 1; e_idx = m_vic; e_off = int'(req_vaddr[31:22]);
                            m_phase = 1;
                        end
                    end else begin
                        e_valid = 0; e_miss = 0;
                    end
                end
                1: begin e_off = int'(m_va[21:12]); m_phase = 2; end
                2: begin e_off = int'(m_va[11:0]);  m_phase = 3; end
                3: begin e_valid = 0; e_miss = 0;   m_phase = 4; end
                default: begin
                    if (fill_valid) begin
                        m_vpn[m_vic] = m_va[31:12];
                        m_vld[m_vic] = 1;
                        touch(m_vic);
                        m_phase = 0;
                    end
                end
            endcase
        end
    end

    task automatic compare();
        chk(spur ? "R6" : "R5", "req_ready", int'(req_ready), int'(m_phase == 0));
        chk(e_valid ? (e_miss ? "R3" : "R2") : "R10", "link_valid", int'(link_valid), int'(e_valid));
        chk(e_valid ? "R3" : "R10", "link_miss", int'(link_miss), int'(e_miss));
        if (e_valid) begin
            chk(e_miss ? "R3" : "R2", "link_offset", int'(link_offset), e_off);
            if (!e_miss)          chk("R9", "hit index", int'(link_index), e_idx);
            else if (m_phase == 1) chk(e_free ? "R7" : "R8", "victim index", int'(link_index), e_idx);
            else                  chk("R4", "victim index held", int'(link_index), e_idx);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int p = 0; p < POOL; p++) pool[p] = 20'($urandom);
        // R1: reset state observed while reset is held
        repeat (3) begin
            @(negedge clk);
            chk("R1", "req_ready in reset", int'(req_ready), 1);
            chk("R1", "link_valid in reset", int'(link_valid), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "req_ready after reset", int'(req_ready), 1);
        chk("R1", "link_valid after reset", int'(link_valid), 0);
        for (int c = 0; c < CYCLES; c++) begin
            logic [19:0] vpn;
            compare();
            req_valid = ($urandom % 4) != 0;
            vpn = (($urandom % 2) == 0) ? pool[$urandom % POOL] : 20'($urandom);
            req_vaddr = {vpn, 12'($urandom)};
            if (m_phase == 4) fill_valid = ($urandom % 3) == 0;
            else              fill_valid = ($urandom % 8) == 0;
            @(negedge clk);
        end
        compare();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

endmodule